// File: doc/BRIEF.md
# Serial Synchronous Register Access Port

This block is a slave port that gives an external host access to an internal register space over a three-wire synchronous serial link. The host pulls chip select low and selects read or write with a direction pin. It shifts in one address byte, most significant bit first, followed by any number of data bytes. For a write, each complete data byte becomes one write strobe on the internal register bus. For a read, the addressed register is fetched as soon as the address byte completes, and its contents are shifted back out on the serial output.

A mode input makes the register address count down by one after every data byte, so a burst reaches descending addresses. With that input low, every byte of the burst goes to the same address. A second mode pin chooses whether the serial output changes on the rising or the falling serial clock edge. All serial pins are brought into the system clock domain through a synchroniser chain and edge-detected there, so the serial clock must be at least four times slower than the system clock.

The internal bus is combinational on the read side: `reg_rdata` must present the contents of `reg_addr` in the cycle in which `reg_re` is high.

Top module: `ssp_regport`

## Requirements
- R1: A transaction spans the time chip select (`cs_n`) is low. Bits of an incomplete byte at the rising edge of `cs_n` are discarded, so the next transaction starts again with a fresh address byte. No strobe is issued while `cs_n` is high.
- R2: The first complete byte of every transaction is taken as the register address. Later bytes are data.
- R3: Serial input is sampled on the rising edge of `sclk`, most significant bit first, for both address and data bytes.
- R4: In a write transaction (`rd_sel` = 0 at the start), each complete data byte produces exactly one `reg_we` pulse, with `reg_wdata` holding that byte and `reg_addr` holding the current address.
- R5: In a read transaction (`rd_sel` = 1 at the start), `reg_re` pulses with `reg_addr` set to the received address as soon as the address byte completes. The returned byte is shifted out on `sdo` most significant bit first as the next data byte.
- R6: With `edge_sel` = 0, `sdo` changes after rising `sclk` edges, and the host samples it on falling edges. With `edge_sel` = 1, `sdo` changes after falling edges, and the host samples it on rising edges. In both cases the first data bit is valid at the first sampling edge after the address byte.
- R7: With `auto_dec` = 1, the address decreases by one after each data byte and wraps from 0x00 to 0xFF. Write bursts then reach descending addresses. Read bursts issue a further `reg_re` after each data byte, at the decremented address. With `auto_dec` = 0, the address stays fixed: a write burst overwrites the same register, and a read burst repeats the same byte with no further `reg_re`.
- R8: `sdo_oe` is high only while the synchronised chip select is active. It falls within four system clocks of `cs_n` rising, and `sdo` is then 0.
- R9: `reg_we` and `reg_re` are single-cycle pulses that never coincide. A read transaction issues no `reg_we`, and a write transaction issues no `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| rd_sel | input | 1 | Direction for the transaction: 1 read, 0 write |
| edge_sel | input | 1 | Output edge: 0 rising, 1 falling |
| auto_dec | input | 1 | 1 makes the address count down per data byte |
| sdo | output | 1 | Serial data to the host |
| sdo_oe | output | 1 | Output enable for the external `sdo` driver |
| reg_addr | output | AW | Internal register address |
| reg_wdata | output | DW | Internal write data |
| reg_we | output | 1 | Internal write strobe |
| reg_re | output | 1 | Internal read strobe |
| reg_rdata | input | DW | Internal read data, valid with `reg_re` |

## Verification
The bound checker watches the strobe discipline on every cycle: single-cycle `reg_we` and `reg_re` pulses, their mutual exclusion, and their absence in the wrong direction. It also checks that the output enable and all strobes are quiet once chip select has been high long enough to pass the synchroniser. Bit order, address capture, countdown with wraparound, the fixed-address burst, the two output-edge timings and the discarding of a partial byte are all matters of data content across a whole transaction. Only the bench's host model can show them, by comparing its model register file and the bytes it samples against the values it expects.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

   // Per-transaction mode, latched when chip select becomes active
   typedef struct packed {
      logic rd;          // 1: read transaction
      logic dec;         // 1: address counts down per data byte
      logic fall_edge;   // 1: output changes on falling serial edge
   } ssp_mode_t;

   localparam int unsigned SSP_MIN_SYNC = 2;

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[0] <= RST_VAL;
      else        stage[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage[g] <= RST_VAL;
         else        stage[g] <= stage[g-1];
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/ssp_rx_frame.sv
module ssp_rx_frame
   import ssp_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_act,
   input  logic          start,
   input  logic          sck_rise,
   input  logic          sdi_s,
   input  logic          rd_sel,
   input  logic          auto_dec,
   input  logic          edge_sel,
   output ssp_mode_t     mode,
   output logic          byte_done,
   output logic          hold_load,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          reg_we,
   output logic          reg_re
);
   localparam int CW = $clog2(DW);

   logic [CW-1:0] bit_cnt;
   logic [DW-1:0] sh;
   logic [DW-1:0] byte_val;
   logic          got_addr;
   logic [AW-1:0] addr_q;

   assign byte_done = cs_act & sck_rise & (bit_cnt == CW'(DW-1));
   assign byte_val  = {sh[DW-2:0], sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         sh        <= '0;
         got_addr  <= 1'b0;
         addr_q    <= '0;
         mode      <= '0;
         reg_addr  <= '0;
         reg_wdata <= '0;
         reg_we    <= 1'b0;
         reg_re    <= 1'b0;
         hold_load <= 1'b0;
      end else begin
         reg_we    <= 1'b0;
         reg_re    <= 1'b0;
         hold_load <= 1'b0;
         if (!cs_act) begin
            bit_cnt  <= '0;
            got_addr <= 1'b0;
         end else begin
            if (start) begin
               mode.rd        <= rd_sel;
               mode.dec       <= auto_dec;
               mode.fall_edge <= edge_sel;
            end
            if (sck_rise) begin
               sh      <= byte_val;
               bit_cnt <= byte_done ? '0 : bit_cnt + CW'(1);
            end
            if (byte_done) begin
               if (!got_addr) begin
                  got_addr <= 1'b1;
                  addr_q   <= byte_val[AW-1:0];
                  reg_addr <= byte_val[AW-1:0];
                  reg_re   <= mode.rd;
               end else if (!mode.rd) begin
                  reg_we    <= 1'b1;
                  reg_addr  <= addr_q;
                  reg_wdata <= byte_val;
                  if (mode.dec) addr_q <= addr_q - AW'(1);
               end else if (mode.dec) begin
                  addr_q   <= addr_q - AW'(1);
                  reg_addr <= addr_q - AW'(1);
                  reg_re   <= 1'b1;
               end else begin
                  hold_load <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ssp_tx_shift.sv
module ssp_tx_shift #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_act,
   input  logic          fall_mode,
   input  logic          sck_rise,
   input  logic          sck_fall,
   input  logic          byte_done,
   input  logic          load_mem,
   input  logic          load_hold,
   input  logic [DW-1:0] mem_data,
   output logic          sdo_bit
);
   logic [DW-1:0] sh;
   logic [DW-1:0] hold;
   logic          fresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         hold  <= '0;
         fresh <= 1'b0;
      end else if (!cs_act) begin
         sh    <= '0;
         fresh <= 1'b0;
      end else if (load_mem) begin
         sh    <= mem_data;
         hold  <= mem_data;
         fresh <= 1'b1;
      end else if (load_hold) begin
         sh    <= hold;
         fresh <= 1'b1;
      end else if (!fall_mode && sck_rise && !byte_done) begin
         sh <= {sh[DW-2:0], 1'b0};
      end else if (fall_mode && sck_fall) begin
         if (!fresh) sh <= {sh[DW-2:0], 1'b0};
         fresh <= 1'b0;
      end
   end

   assign sdo_bit = sh[DW-1];
endmodule

// File: rtl/ssp_regport.sv
module ssp_regport
   import ssp_pkg::*;
#(
   parameter int DW          = 8,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          sclk,
   input  logic          sdi,
   input  logic          rd_sel,
   input  logic          edge_sel,
   input  logic          auto_dec,
   output logic          sdo,
   output logic          sdo_oe,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   output logic          reg_we,
   output logic          reg_re,
   input  logic [DW-1:0] reg_rdata
);
   if (DW < 4 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("ssp_regport: DW must be a power of two of at least 4");
   end
   if (AW < 1 || AW > DW) begin : g_bad_aw
      $error("ssp_regport: AW must lie in 1..DW");
   end
   if (SYNC_STAGES < SSP_MIN_SYNC) begin : g_bad_sync
      $error("ssp_regport: SYNC_STAGES below minimum");
   end

   logic [2:0] raw_in, syn;
   logic       cs_s, sck_s, sdi_s;
   logic       cs_d, sck_d;
   logic       cs_act, start, sck_rise, sck_fall;
   logic       byte_done, hold_load, sdo_bit, rd_mode;
   ssp_mode_t  mode;

   assign raw_in = {cs_n, sclk, sdi};

   ssp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   assign {cs_s, sck_s, sdi_s} = syn;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign cs_act   = ~cs_s;
   assign start    = ~cs_s & cs_d;
   assign sck_rise = sck_s & ~sck_d;
   assign sck_fall = ~sck_s & sck_d;

   ssp_rx_frame #(.DW(DW), .AW(AW)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .start(start),
      .sck_rise(sck_rise), .sdi_s(sdi_s), .rd_sel(rd_sel),
      .auto_dec(auto_dec), .edge_sel(edge_sel), .mode(mode),
      .byte_done(byte_done), .hold_load(hold_load),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_re(reg_re)
   );

   ssp_tx_shift #(.DW(DW)) u_tx (
      .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
      .fall_mode(mode.fall_edge), .sck_rise(sck_rise), .sck_fall(sck_fall),
      .byte_done(byte_done), .load_mem(reg_re), .load_hold(hold_load),
      .mem_data(reg_rdata), .sdo_bit(sdo_bit)
   );

   assign rd_mode = mode.rd;
   assign sdo_oe  = cs_act;
   assign sdo     = cs_act & sdo_bit;
endmodule

// File: rtl/ssp_regport_chk.sv
module ssp_regport_chk (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic reg_we,
   input logic reg_re,
   input logic sdo_oe,
   input logic rd_mode
);
   // R9: write strobe lasts one cycle
   a_r9_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   // R9: read strobe lasts one cycle
   a_r9_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);
   // R9: strobes never coincide
   a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));
   // R9: no write strobe in a read transaction
   a_r9_no_we_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode |-> !reg_we);
   // R9: read strobe only in a read transaction
   a_r9_re_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> rd_mode);
   // R1 / R8: quiet once chip select has been high past the synchroniser
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
         |-> (!sdo_oe && !reg_we && !reg_re));
endmodule

bind ssp_regport ssp_regport_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .reg_we(reg_we),
   .reg_re(reg_re), .sdo_oe(sdo_oe), .rd_mode(rd_mode)
);

// File: tb/tb_ssp_regport.sv
`timescale 1ns/1ps
module tb_ssp_regport;
   localparam int H  = 120;     // half serial period, ns
   localparam int NV = 9;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic       rd_sel = 1'b0, edge_sel = 1'b0, auto_dec = 1'b0;
   logic       sdo, sdo_oe, reg_we, reg_re;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;

   logic [7:0] mem [256];
   int         we_cnt, re_cnt;
   int         total = 0, bad = 0;
   bit         done = 1'b0;

   logic [7:0] txb [3];
   logic       rs [24];
   logic       fs [24];

   always #10 clk = ~clk;

   ssp_regport dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .rd_sel(rd_sel), .edge_sel(edge_sel), .auto_dec(auto_dec),
      .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
      .reg_rdata(reg_rdata)
   );

   // Model register file
   assign reg_rdata = mem[reg_addr];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
         we_cnt <= 0;
         re_cnt <= 0;
      end else begin
         if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
         end
         if (reg_re) re_cnt <= re_cnt + 1;
      end
   end

   // {rd, ade, edg, nb[1:0], addr, d0, d1}
   localparam logic [28:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b0, 2'd1, 8'h3C, 8'hA5, 8'h00},
      {1'b0, 1'b1, 1'b1, 2'd2, 8'h10, 8'h11, 8'h22},
      {1'b0, 1'b0, 1'b0, 2'd2, 8'h20, 8'h55, 8'h66},
      {1'b1, 1'b0, 1'b0, 2'd1, 8'h3C, 8'hA5, 8'h00},
      {1'b1, 1'b0, 1'b1, 2'd2, 8'h3C, 8'hA5, 8'hA5},
      {1'b1, 1'b1, 1'b0, 2'd2, 8'h10, 8'h11, 8'h22},
      {1'b1, 1'b1, 1'b1, 2'd2, 8'h10, 8'h11, 8'h22},
      {1'b0, 1'b1, 1'b0, 2'd2, 8'h00, 8'h5A, 8'hC3},
      {1'b1, 1'b1, 1'b1, 2'd2, 8'h00, 8'h5A, 8'hC3}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_xfer(input logic rd, input logic ade, input logic edg, input int nbits);
      rd_sel = rd; auto_dec = ade; edge_sel = edg;
      #(H); cs_n = 1'b0; #(H);
      for (int it = 0; it < nbits; it++) begin
         sdi = txb[it/8][7 - (it % 8)];
         #(H);
         rs[it] = sdo;
         sclk = 1'b1;
         #(H);
         fs[it] = sdo;
         sclk = 1'b0;
      end
      #(H); cs_n = 1'b1; #(2*H);
   endtask

   function automatic logic [7:0] got_byte(input int k, input logic edg);
      logic [7:0] r;
      for (int b = 7; b >= 0; b--) begin
         r[b] = edg ? rs[(k+1)*8 + (7-b)] : fs[(k+1)*8 + (7-b) - 1];
      end
      return r;
   endfunction

   initial begin
      #3;
      repeat (5) @(posedge clk);
      #3; rst_n = 1'b1;
      #40;
      // R8 / R1: reset state
      chk("R8 reset sdo_oe", sdo_oe, 0);
      chk("R1 reset reg_we", reg_we, 0);
      chk("R9 reset reg_re", reg_re, 0);

      for (int i = 0; i < NV; i++) begin
         logic       rd, ade, edg;
         logic [1:0] nb;
         logic [7:0] a, d0, d1;
         int         w0, r0;
         {rd, ade, edg, nb, a, d0, d1} = VEC[i];
         txb[0] = a;
         txb[1] = rd ? 8'h00 : d0;
         txb[2] = rd ? 8'h00 : d1;
         w0 = we_cnt; r0 = re_cnt;
         run_xfer(rd, ade, edg, 8 * (1 + int'(nb)));
         if (!rd) begin
            chk($sformatf("R4 write count vec%0d", i), we_cnt - w0, int'(nb));
            chk($sformatf("R9 no re in write vec%0d", i), re_cnt - r0, 0);
            if (nb == 2'd2 && !ade)
               chk($sformatf("R7 fixed addr vec%0d", i), mem[a], d1);
            else
               chk($sformatf("R2/R3 first data at addr vec%0d", i), mem[a], d0);
            if (nb == 2'd2 && ade)
               chk($sformatf("R7 decremented addr vec%0d", i), mem[a - 8'd1], d1);
         end else begin
            chk($sformatf("R5/R6 first byte vec%0d", i), got_byte(0, edg), d0);
            if (nb == 2'd2)
               chk($sformatf("R7 second byte vec%0d", i), got_byte(1, edg), d1);
            chk($sformatf("R5 re count vec%0d", i), re_cnt - r0, 1 + (ade ? int'(nb) : 0));
            chk($sformatf("R9 no we in read vec%0d", i), we_cnt - w0, 0);
         end
      end

      // R8: enable follows chip select
      #(H); cs_n = 1'b0; #200;
      chk("R8 oe while selected", sdo_oe, 1);
      cs_n = 1'b1; #100;
      chk("R8 oe after deselect", sdo_oe, 0);
      chk("R8 sdo after deselect", sdo, 0);
      #(2*H);

      // R1: partial byte is discarded
      begin
         int w0;
         w0 = we_cnt;
         txb[0] = 8'h40; txb[1] = 8'h99; txb[2] = 8'h00;
         run_xfer(1'b0, 1'b0, 1'b0, 12);
         chk("R1 partial byte no write", we_cnt - w0, 0);
         chk("R1 partial byte mem untouched", mem[8'h40], 0);
         txb[0] = 8'h41; txb[1] = 8'h77;
         run_xfer(1'b0, 1'b0, 1'b0, 16);
         chk("R1 next transaction reframed", mem[8'h41], 8'h77);
         chk("R1 next transaction one write", we_cnt - w0, 1);
      end

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #3_000_000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule